// File: doc/BRIEF.md
# Four-Channel External Interrupt Detector

This block watches four external interrupt pins and turns their activity into interrupt requests for an interrupt controller. Each pin has one mode bit and one polarity bit. Together they select one of four trigger types: active-high level, active-low level, rising edge or falling edge. Every pin first passes through a two-flop synchroniser. A per-channel state machine then produces a status flag, and that flag drives the matching interrupt request output.

Edge flags latch and stay set until software clears them by writing 1 to the flag bit. Level flags track the pin while the selected level is present. Software cannot clear a level flag for good while the level is still present. The detector always compares the current polarity-adjusted pin value with the value it had one cycle earlier. Rewriting the polarity in edge mode can therefore produce a one-off spurious edge. Software removes it with a clear straight after the write.

Each channel state machine has three states:
- CH_QUIET: the flag is low.
- CH_LATCHED: an edge flag is held.
- CH_ASSERT: a level flag is active.

Its transitions are:
- In edge mode:
  - QUIET→LATCHED when an edge is detected.
  - LATCHED→LATCHED while the flag is not cleared, or when a new edge arrives.
  - LATCHED→QUIET when a clear arrives without a new edge.
  - ASSERT→LATCHED or ASSERT→QUIET after a switch to edge mode, by the same rules as LATCHED.
- In level mode: any state→ASSERT while the level is active, and any state→QUIET when it is not.

Top module: `ext_irq_detect`

## Requirements
- R1: After reset all flags and requests are 0, the mode register reads 0000 (all level) and the polarity register reads 1111 (all active-high / rising).
- R2: A write to the mode or polarity register loads all four bits on the write cycle and reads back from the next cycle. Bit n of each register belongs to channel n. Mode bit 0 = level, 1 = edge. Polarity bit 1 = high/rising, 0 = low/falling.
- R3: In edge mode with polarity 1, a 0→1 change on the pin sets the flag exactly three clock edges after the edge at which the new pin value is first sampled, counting that edge. The flag is not set one edge earlier.
- R4: In edge mode with polarity 0, a 1→0 change on the pin sets the flag with the same latency. A 0→1 change does not set it.
- R5: An edge flag stays set after the pin returns to its idle level, until it is cleared.
- R6: Writing the clear mask clears, one edge later, exactly the edge flags whose mask bit is 1. Flags whose mask bit is 0 keep their value.
- R7: If a clear and a new selected edge arrive for a channel in the same cycle, the flag stays set.
- R8: In level mode with polarity 1, the flag follows the synchronised pin. It rises and falls three edges after the pin changes.
- R9: In level mode with polarity 0, the flag is set while the pin is low and is 0 while the pin is high.
- R10: In level mode, a clear while the active level is present leaves the flag at 1.
- R11: In edge mode with a steady pin, flipping the polarity so that the pin value becomes the active one sets a spurious flag two edges after the write. A clear written straight afterwards removes it, and it stays clear.
- R12: irq_req[n] equals flag_q[n] in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 4 | Asynchronous external interrupt pins |
| mode_we | input | 1 | Mode register write strobe |
| mode_wdata | input | 4 | Mode write data (1 = edge) |
| pol_we | input | 1 | Polarity register write strobe |
| pol_wdata | input | 4 | Polarity write data (1 = high/rising) |
| clr_we | input | 1 | Flag clear strobe |
| clr_mask | input | 4 | Write-1-to-clear mask |
| mode_q | output | 4 | Mode register contents |
| pol_q | output | 4 | Polarity register contents |
| flag_q | output | 4 | Flag status |
| irq_req | output | 4 | Interrupt requests to the controller |

## Verification
A pin change is due on the flag three edges after it is first sampled: two synchroniser flops plus the state register. A polarity write takes two edges to reach the flag, and a clear takes one. Directed checks count exactly that many edges with the tick task and sample at the falling edge after them. They also sample one edge early, to show that the flag has not yet moved. The random phase drives inputs at the falling edge and advances a bench reference of the same cycle timing at every rising edge. It then compares flags and requests at the following falling edge.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
    typedef enum logic [1:0] {
        CH_QUIET   = 2'd0,
        CH_LATCHED = 2'd1,
        CH_ASSERT  = 2'd2
    } ch_state_e;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
        end else begin
            stage_q[0] <= async_in;
            for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/ext_irq_cfg.sv
module ext_irq_cfg #(
    parameter int               NUM_CH    = 4,
    parameter logic [NUM_CH-1:0] MODE_RST = '0,
    parameter logic [NUM_CH-1:0] POL_RST  = '1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_we,
    input  logic [NUM_CH-1:0] mode_wdata,
    input  logic              pol_we,
    input  logic [NUM_CH-1:0] pol_wdata,
    output logic [NUM_CH-1:0] mode_q,
    output logic [NUM_CH-1:0] pol_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= MODE_RST;
            pol_q  <= POL_RST;
        end else begin
            if (mode_we) mode_q <= mode_wdata;
            if (pol_we)  pol_q  <= pol_wdata;
        end
    end

    // R2: a write is visible on the next cycle
    a_r2_mode_load: assert property (@(posedge clk) disable iff (!rst_n)
        mode_we |=> (mode_q == $past(mode_wdata)));
    a_r2_pol_load: assert property (@(posedge clk) disable iff (!rst_n)
        pol_we |=> (pol_q == $past(pol_wdata)));
endmodule

// File: rtl/ext_irq_chan.sv
module ext_irq_chan
    import ext_irq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic pin_s,
    input  logic mode_edge,
    input  logic pol_high,
    input  logic clr,
    output logic flag
);
    ch_state_e state_q, state_d;
    logic      active;
    logic      active_prev_q;
    logic      edge_hit;

    assign active   = pol_high ? pin_s : ~pin_s;
    assign edge_hit = active & ~active_prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q       <= CH_QUIET;
            active_prev_q <= 1'b0;
        end else begin
            state_q       <= state_d;
            active_prev_q <= active;
        end
    end

    always_comb begin
        state_d = state_q;
        if (mode_edge) begin
            unique case (state_q)
                CH_QUIET:   state_d = edge_hit ? CH_LATCHED : CH_QUIET;
                CH_LATCHED,
                CH_ASSERT:  state_d = (edge_hit || !clr) ? CH_LATCHED : CH_QUIET;
                default:    state_d = CH_QUIET;
            endcase
        end else begin
            state_d = active ? CH_ASSERT : CH_QUIET;
        end
    end

    always_comb begin
        flag = (state_q != CH_QUIET);
    end

    // R3: a detected edge sets the flag
    a_r3_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_edge && edge_hit) |=> flag);
    // R5: an edge flag holds without a clear
    a_r5_edge_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_edge && flag && !clr) |=> flag);
    // R6: a clear without a new edge drops the flag
    a_r6_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_edge && flag && clr && !edge_hit) |=> !flag);
    // R8: level flag tracks the active level
    a_r8_level_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_edge |=> (flag == $past(active)));
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect #(
    parameter int NUM_CH      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ext_pin,
    input  logic              mode_we,
    input  logic [NUM_CH-1:0] mode_wdata,
    input  logic              pol_we,
    input  logic [NUM_CH-1:0] pol_wdata,
    input  logic              clr_we,
    input  logic [NUM_CH-1:0] clr_mask,
    output logic [NUM_CH-1:0] mode_q,
    output logic [NUM_CH-1:0] pol_q,
    output logic [NUM_CH-1:0] flag_q,
    output logic [NUM_CH-1:0] irq_req
);
    logic [NUM_CH-1:0] pin_sync;
    logic [NUM_CH-1:0] clr_vec;

    assign clr_vec = clr_we ? clr_mask : '0;

    ext_irq_sync #(.WIDTH(NUM_CH), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_pin),
        .sync_out (pin_sync)
    );

    ext_irq_cfg #(.NUM_CH(NUM_CH)) u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode_we    (mode_we),
        .mode_wdata (mode_wdata),
        .pol_we     (pol_we),
        .pol_wdata  (pol_wdata),
        .mode_q     (mode_q),
        .pol_q      (pol_q)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        ext_irq_chan u_chan (
            .clk       (clk),
            .rst_n     (rst_n),
            .pin_s     (pin_sync[g]),
            .mode_edge (mode_q[g]),
            .pol_high  (pol_q[g]),
            .clr       (clr_vec[g]),
            .flag      (flag_q[g])
        );
    end

    always_comb begin
        irq_req = flag_q;
    end

    // R10: a clear in level mode with the level present does not drop the flag
    a_r10_level_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_we && (clr_mask == 4'hF) && (mode_q == 4'h0) && (pin_sync == pol_q)
         && !mode_we && !pol_we) |=> (flag_q == 4'hF));
endmodule

// File: tb/ext_irq_detect_test.sv
module ext_irq_detect_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] ext_pin = '0;
    logic       mode_we = 1'b0, pol_we = 1'b0, clr_we = 1'b0;
    logic [3:0] mode_wdata = '0, pol_wdata = '0, clr_mask = '0;
    logic [3:0] mode_q, pol_q, flag_q, irq_req;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    // reference state
    logic [3:0] m_p1, m_p2, m_prev, m_flag, m_mode, m_pol;

    always #10 clk = ~clk;

    ext_irq_detect uut (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin),
        .mode_we(mode_we), .mode_wdata(mode_wdata),
        .pol_we(pol_we), .pol_wdata(pol_wdata),
        .clr_we(clr_we), .clr_mask(clr_mask),
        .mode_q(mode_q), .pol_q(pol_q), .flag_q(flag_q), .irq_req(irq_req)
    );

    function automatic logic [3:0] act_of(input logic [3:0] p, input logic [3:0] pol);
        return ~(p ^ pol);
    endfunction

    function automatic logic [3:0] next_flag(input logic [3:0] act, input logic [3:0] prev,
                                             input logic [3:0] flag, input logic [3:0] mode,
                                             input logic [3:0] clr);
        logic [3:0] edg = act & ~prev;
        return (mode & (edg | (flag & ~clr))) | (~mode & act);
    endfunction

    task automatic chk(input string tag, input logic [3:0] got, input logic [3:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic tick();
        logic [3:0] act;
        @(posedge clk);
        act    = act_of(m_p2, m_pol);
        m_flag = next_flag(act, m_prev, m_flag, m_mode, clr_we ? clr_mask : 4'h0);
        m_prev = act;
        m_p2   = m_p1;
        m_p1   = ext_pin;
        if (mode_we) m_mode = mode_wdata;
        if (pol_we)  m_pol  = pol_wdata;
        @(negedge clk);
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic wr_mode(input logic [3:0] v);
        mode_we = 1'b1; mode_wdata = v; tick(); mode_we = 1'b0;
    endtask
    task automatic wr_pol(input logic [3:0] v);
        pol_we = 1'b1; pol_wdata = v; tick(); pol_we = 1'b0;
    endtask
    task automatic wr_clr(input logic [3:0] v);
        clr_we = 1'b1; clr_mask = v; tick(); clr_we = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        int unsigned seed;
        m_p1 = '0; m_p2 = '0; m_prev = '0; m_flag = '0; m_mode = '0; m_pol = 4'hF;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 flag", flag_q, 4'h0);
        chk("R1 mode", mode_q, 4'h0);
        chk("R1 pol", pol_q, 4'hF);
        chk("R1 irq", irq_req, 4'h0);
        rst_n = 1'b1;
        tick();

        // R2 register load
        wr_mode(4'b0011);
        chk("R2 mode", mode_q, 4'b0011);
        wr_pol(4'b1101);
        chk("R2 pol", pol_q, 4'b1101);
        // ch0 edge rising, ch1 edge falling, ch2 level high, ch3 level high
        ext_pin = 4'b0010;          // ch1 idle high
        ticks(4);
        wr_clr(4'hF);
        chk("R2 settle", flag_q & 4'b0011, 4'b0000);

        // R3 rising edge latency
        ext_pin[0] = 1'b1;
        ticks(2);
        chk("R3 early", flag_q[0], 1'b0);
        tick();
        chk("R3 set", flag_q[0], 1'b1);
        // R5 hold after pin returns
        ext_pin[0] = 1'b0;
        ticks(4);
        chk("R5 hold", flag_q[0], 1'b1);

        // R4 falling edge, ch1
        ext_pin[1] = 1'b0;
        ticks(3);
        chk("R4 fall", flag_q[1], 1'b1);
        wr_clr(4'b0010);
        chk("R6 masked", flag_q[1:0], 2'b01);
        ext_pin[1] = 1'b1;
        ticks(4);
        chk("R4 no rise", flag_q[1], 1'b0);
        wr_clr(4'b0001);
        chk("R6 clear", flag_q[1:0], 2'b00);

        // R7 set beats clear: new rising edge on ch0 reaches detector while clearing
        ext_pin[0] = 1'b1;
        ticks(2);
        wr_clr(4'b0001);
        chk("R7 set wins", flag_q[0], 1'b1);
        ext_pin[0] = 1'b0;
        wr_clr(4'b0001);
        chk("R7 later clear", flag_q[0], 1'b0);

        // R8 level high, ch2
        ext_pin[2] = 1'b1;
        ticks(2);
        chk("R8 early", flag_q[2], 1'b0);
        tick();
        chk("R8 rise", flag_q[2], 1'b1);
        // R10 clear with level present
        wr_clr(4'b0100);
        chk("R10 level stays", flag_q[2], 1'b1);
        ext_pin[2] = 1'b0;
        ticks(3);
        chk("R8 fall", flag_q[2], 1'b0);

        // R9 level low on ch3
        ext_pin[3] = 1'b1;
        wr_pol(4'b0101);
        ticks(3);
        chk("R9 inactive", flag_q[3], 1'b0);
        ext_pin[3] = 1'b0;
        ticks(3);
        chk("R9 active", flag_q[3], 1'b1);
        ext_pin[3] = 1'b1;
        ticks(3);
        chk("R9 release", flag_q[3], 1'b0);

        // R11 spurious flag on polarity flip, ch0 edge mode, pin steady low
        wr_clr(4'hF);
        chk("R11 pre", flag_q[0], 1'b0);
        wr_pol(4'b0100);
        chk("R11 one edge", flag_q[0], 1'b0);
        tick();
        chk("R11 spurious", flag_q[0], 1'b1);
        wr_clr(4'b0001);
        chk("R11 cleared", flag_q[0], 1'b0);
        ticks(3);
        chk("R11 stays", flag_q[0], 1'b0);
        chk("R12 irq", irq_req, flag_q);

        // random phase against the reference
        seed = 32'd20240611;
        void'($urandom(seed));
        for (int c = 0; c < 3000; c++) begin
            int unsigned r = $urandom();
            if (r[3:0] < 4'd5) ext_pin = ext_pin ^ 4'(r >> 8);
            mode_we = (r[7:4] == 4'd0);
            mode_wdata = 4'(r >> 12);
            pol_we = (r[7:4] == 4'd1);
            pol_wdata = 4'(r >> 16);
            clr_we = (r[7:5] == 3'd7);
            clr_mask = 4'(r >> 20);
            tick();
            mode_we = 1'b0; pol_we = 1'b0; clr_we = 1'b0;
            chk("R3 random flag", flag_q, m_flag);
            chk("R12 random irq", irq_req, m_flag);
            chk("R2 random cfg", mode_q, m_mode);
        end
        finish_run();
    end
endmodule